// File: doc/BRIEF.md
# NOR Flash Program and Sector-Erase Sequencer

This block is a bus master for an asynchronous parallel NOR flash. A client hands it one request at a time on a valid/ready port. A request either programs one bus word or erases one sector. The sequencer produces the multi-write command sequence for that request. Every sequence opens with a fixed two-write unlock preamble. The block then watches the device's status-toggle bit until the internal operation settles, and finally reads the result back to confirm it.

The bus can be 1, 2 or 4 bytes wide. Command word addresses are scaled to byte addresses by the bus width and are placed relative to the base of the flash device that holds the target. On a 4-byte bus, the block can also drive two 16-bit devices side by side. In that case every command byte goes to both halves, and each half's status toggle is watched on its own. Each request ends with a one-cycle completion pulse. Two flags ride on that pulse: one for a timeout and one for a read-back mismatch.

Top module: `nor_prog_seq`

## Requirements
- R1: After reset, `cmd_ready` is 1, `done` is 0, and `fl_ce_n`, `fl_we_n` and `fl_oe_n` are all 1.
- R2: An unlock or command write to word address W goes to byte address `base + W*BUS_BYTES`. Here `base` is the request address with its low `CHIP_AW` bits cleared. The two unlock word addresses are 0x555 and 0x2AA.
- R3: A program request produces exactly four writes, in this order: 0xAA to 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, and then the data word to the request address.
- R4: An erase request produces exactly six writes, in this order: 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, and then 0x30 to the sector address.
- R5: With `INTERLEAVE`=1 on a 4-byte bus, each command byte appears in bits 7:0 and in bits 23:16, and all other bits are zero. The program data word is written unchanged.
- R6: A write cycle holds `fl_ce_n` and `fl_we_n` low for exactly `STROBE_CLKS` clocks. Address and data stay stable during that time, and `fl_we_n` and `fl_oe_n` are never low together.
- R7: The device counts as busy while two back-to-back reads of the target differ in bit 6. With interleave, bits 6 and 22 are compared separately, and a toggle in either half means busy.
- R8: After a program completes, the target is read once. Any difference from the written data sets `verify_err` with `done`.
- R9: After an erase completes, every bus word of the `SECTOR_BYTES` sector is read in turn. Any word that is not all ones sets `verify_err` with `done`.
- R10: If the device is still toggling when the poll window runs out, `done` comes with `timeout`=1 and `verify_err`=0. The window is `PROG_TIMEOUT` clocks for a program and `ERASE_TIMEOUT` clocks for an erase, counted from the start of polling.
- R11: `cmd_ready` drops on the clock after a request is accepted and returns with the one-cycle `done` pulse. While it is low, `cmd_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Request present |
| cmd_ready | output | 1 | Sequencer idle, request accepted when valid |
| cmd_erase | input | 1 | 1 = sector erase, 0 = word program |
| cmd_addr | input | ADDR_W | Byte address of target word or sector |
| cmd_data | input | 8*BUS_BYTES | Word to program |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Poll window expired (valid with done) |
| verify_err | output | 1 | Read-back mismatch (valid with done) |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_dq_out | output | 8*BUS_BYTES | Data driven to flash |
| fl_dq_oe | output | 1 | Data output enable for the pad |
| fl_dq_in | input | 8*BUS_BYTES | Data from flash |
| fl_ce_n | output | 1 | Chip enable, active low |
| fl_we_n | output | 1 | Write enable, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The hardest case to reach from the ports is the interleaved device pair where only one half is still toggling. A sequencer that checked only the low half would leave polling early, and it would then read back a status value instead of data. The bench's flash model can be told to toggle bit 22 alone for a chosen number of reads. The only way a program then ends cleanly is if the sequencer keeps polling until the upper half settles. Timeouts are reached by a model mode that never stops toggling, and the completion latency is measured against each operation's window.

// File: rtl/nor_seq_pkg.sv
// Package: shared state encodings and command bytes for the NOR sequencer.
// Assumes: command bytes are 8 bits and are widened per bus by the top.
package nor_seq_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CMD,
        SQ_POLL_A,
        SQ_POLL_B,
        SQ_VERIFY
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } bus_phase_t;

    localparam logic [11:0] WORD_UNLOCK_A = 12'h555;
    localparam logic [11:0] WORD_UNLOCK_B = 12'h2AA;
    localparam logic [7:0]  KEY_FIRST     = 8'hAA;
    localparam logic [7:0]  KEY_SECOND    = 8'h55;
    localparam logic [7:0]  OP_PROGRAM    = 8'hA0;
    localparam logic [7:0]  OP_ERASE_ARM  = 8'h80;
    localparam logic [7:0]  OP_ERASE_GO   = 8'h30;
endpackage

// File: rtl/nor_bus_cycle.sv
// Module: nor_bus_cycle
// Runs one asynchronous flash bus cycle (read or write) per start pulse:
// setup clocks with strobes idle, a strobe window, then hold clocks.
// Assumes: start is only raised when the previous cycle has acked; all
// phase lengths are at least one clock.
module nor_bus_cycle
    import nor_seq_pkg::*;
#(
    parameter int AW          = 24,
    parameter int DW          = 16,
    parameter int SETUP_CLKS  = 1,
    parameter int STROBE_CLKS = 2,
    parameter int HOLD_CLKS   = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_in,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n
);
    localparam int PH_MAX = (SETUP_CLKS > STROBE_CLKS) ?
                            ((SETUP_CLKS > HOLD_CLKS) ? SETUP_CLKS : HOLD_CLKS) :
                            ((STROBE_CLKS > HOLD_CLKS) ? STROBE_CLKS : HOLD_CLKS);
    localparam int CW = $clog2(PH_MAX + 1);
    localparam logic [CW-1:0] SETUP_LOAD  = CW'(SETUP_CLKS - 1);
    localparam logic [CW-1:0] STROBE_LOAD = CW'(STROBE_CLKS - 1);
    localparam logic [CW-1:0] HOLD_LOAD   = CW'(HOLD_CLKS - 1);

    bus_phase_t    phase;
    logic [CW-1:0] cnt;
    logic          wr_q;

    // Phase sequencing, strobe generation and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            cnt       <= '0;
            wr_q      <= 1'b0;
            ack       <= 1'b0;
            rdata     <= '0;
            fl_addr   <= '0;
            fl_dq_out <= '0;
            fl_dq_oe  <= 1'b0;
            fl_ce_n   <= 1'b1;
            fl_we_n   <= 1'b1;
            fl_oe_n   <= 1'b1;
        end else begin
            ack <= 1'b0;
            case (phase)
                PH_IDLE: if (start) begin
                    phase     <= PH_SETUP;
                    cnt       <= SETUP_LOAD;
                    wr_q      <= wr;
                    fl_addr   <= addr;
                    fl_dq_out <= wdata;
                    fl_dq_oe  <= wr;
                end
                PH_SETUP: if (cnt == '0) begin
                    phase   <= PH_STROBE;
                    cnt     <= STROBE_LOAD;
                    fl_ce_n <= 1'b0;
                    fl_we_n <= !wr_q;
                    fl_oe_n <= wr_q;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_STROBE: if (cnt == '0) begin
                    phase   <= PH_HOLD;
                    cnt     <= HOLD_LOAD;
                    fl_ce_n <= 1'b1;
                    fl_we_n <= 1'b1;
                    fl_oe_n <= 1'b1;
                    if (!wr_q) rdata <= fl_dq_in;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: if (cnt == '0) begin
                    phase    <= PH_IDLE;
                    fl_dq_oe <= 1'b0;
                    ack      <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fl_we_n && !fl_oe_n));
    assert_ce_covers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n || !fl_oe_n) |-> !fl_ce_n);
    assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));
endmodule

// File: rtl/nor_toggle_cmp.sv
// Module: nor_toggle_cmp
// Flags the device busy when two successive status reads differ in the
// toggle bit; with a split bus each 16-bit half is judged on its own.
// Assumes: SPLIT is only set for a 32-bit bus.
module nor_toggle_cmp #(
    parameter int DW    = 16,
    parameter int SPLIT = 0
) (
    input  logic [DW-1:0] first_rd,
    input  logic [DW-1:0] second_rd,
    output logic          toggling
);
    localparam int LANES    = (SPLIT != 0) ? 2 : 1;
    localparam int LANE_W   = 16;
    localparam int TOG_BIT  = 6;

    logic [LANES-1:0] lane_tog;

    // One comparator per independently polled device.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_tog[g] = first_rd[g*LANE_W + TOG_BIT] ^ second_rd[g*LANE_W + TOG_BIT];
    end

    // Any lane still toggling keeps the bus busy.
    always_comb toggling = |lane_tog;
endmodule

// File: rtl/nor_op_timer.sv
// Module: nor_op_timer
// Down-counter bounding the poll phase; loaded with the program or erase
// window and reporting expiry when it reaches zero.
// Assumes: load is pulsed once at poll start.
module nor_op_timer #(
    parameter int PROG_TIMEOUT  = 2000,
    parameter int ERASE_TIMEOUT = 40000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic is_erase,
    output logic expired
);
    localparam int TMAX = (ERASE_TIMEOUT > PROG_TIMEOUT) ? ERASE_TIMEOUT : PROG_TIMEOUT;
    localparam int TW   = $clog2(TMAX + 1);

    logic [TW-1:0] remain;

    // Reload on poll start, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           remain <= '0;
        else if (load)        remain <= is_erase ? TW'(ERASE_TIMEOUT) : TW'(PROG_TIMEOUT);
        else if (remain != 0) remain <= remain - 1'b1;
    end

    // Expiry is a plain zero detect on the counter.
    always_comb expired = (remain == '0);
endmodule

// File: rtl/nor_prog_seq.sv
// Module: nor_prog_seq (top)
// Accepts one program or sector-erase request, issues the unlock and command
// writes, polls the toggle bit until stable or the window expires, then
// verifies by reading back. Reports done with timeout / verify_err flags.
// Assumes: cmd_addr is bus-word aligned (sector aligned for erase);
// INTERLEAVE is only set with BUS_BYTES = 4.
module nor_prog_seq
    import nor_seq_pkg::*;
#(
    parameter int BUS_BYTES     = 2,
    parameter int INTERLEAVE    = 0,
    parameter int ADDR_W        = 24,
    parameter int CHIP_AW       = 21,
    parameter int SECTOR_BYTES  = 65536,
    parameter int SETUP_CLKS    = 1,
    parameter int STROBE_CLKS   = 2,
    parameter int HOLD_CLKS     = 1,
    parameter int PROG_TIMEOUT  = 2000,
    parameter int ERASE_TIMEOUT = 40000,
    localparam int DW           = 8 * BUS_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DW-1:0]     cmd_data,
    output logic              done,
    output logic              timeout,
    output logic              verify_err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DW-1:0]     fl_dq_out,
    output logic              fl_dq_oe,
    input  logic [DW-1:0]     fl_dq_in,
    output logic              fl_ce_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    localparam int BB_LOG2     = $clog2(BUS_BYTES);
    localparam int SECT_WORDS  = SECTOR_BYTES / BUS_BYTES;
    localparam int VW          = (SECT_WORDS > 1) ? $clog2(SECT_WORDS) : 1;
    localparam logic [VW-1:0] LAST_WORD = VW'(SECT_WORDS - 1);
    localparam logic [ADDR_W-1:0] CHIP_MASK = ADDR_W'((64'd1 << CHIP_AW) - 64'd1);
    localparam logic [ADDR_W-1:0] OFS_A = ADDR_W'(64'(WORD_UNLOCK_A) << BB_LOG2);
    localparam logic [ADDR_W-1:0] OFS_B = ADDR_W'(64'(WORD_UNLOCK_B) << BB_LOG2);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(BUS_BYTES);

    // Widen a command byte to a bus word, copying it into each device lane.
    function automatic logic [DW-1:0] cmd_word(input logic [7:0] c);
        logic [DW-1:0] w;
        w = '0;
        for (int i = 0; i < DW; i++) begin
            if ((i % 16) < 8 && (INTERLEAVE != 0 || i < 8)) w[i] = c[i % 8];
        end
        return w;
    endfunction

    seq_state_t        state;
    logic              is_erase_q;
    logic [ADDR_W-1:0] tgt_q;
    logic [DW-1:0]     data_q;
    logic [2:0]        step;
    logic              wait_ack;
    logic [DW-1:0]     sample_a;
    logic [ADDR_W-1:0] vaddr;
    logic [VW-1:0]     vidx;
    logic              timer_load;

    logic              bus_start;
    logic              bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DW-1:0]     bus_wdata;
    logic              bus_ack;
    logic [DW-1:0]     bus_rdata;
    logic              toggling;
    logic              expired;

    logic [ADDR_W-1:0] chip_base;
    logic [ADDR_W-1:0] step_addr;
    logic [DW-1:0]     step_data;
    logic [2:0]        last_step;
    logic [DW-1:0]     verify_expect;

    // Decode the current command step into bus address and data.
    always_comb begin
        chip_base     = tgt_q & ~CHIP_MASK;
        last_step     = is_erase_q ? 3'd5 : 3'd3;
        verify_expect = is_erase_q ? '1 : data_q;
        step_addr     = tgt_q;
        step_data     = data_q;
        if (!is_erase_q) begin
            case (step)
                3'd0:    begin step_addr = chip_base | OFS_A; step_data = cmd_word(KEY_FIRST);  end
                3'd1:    begin step_addr = chip_base | OFS_B; step_data = cmd_word(KEY_SECOND); end
                3'd2:    begin step_addr = chip_base | OFS_A; step_data = cmd_word(OP_PROGRAM); end
                default: begin step_addr = tgt_q;             step_data = data_q;               end
            endcase
        end else begin
            case (step)
                3'd0, 3'd3: begin step_addr = chip_base | OFS_A; step_data = cmd_word(KEY_FIRST);    end
                3'd1, 3'd4: begin step_addr = chip_base | OFS_B; step_data = cmd_word(KEY_SECOND);   end
                3'd2:       begin step_addr = chip_base | OFS_A; step_data = cmd_word(OP_ERASE_ARM); end
                default:    begin step_addr = tgt_q;             step_data = cmd_word(OP_ERASE_GO);  end
            endcase
        end
    end

    // Request intake, command stepping, polling, verification and reporting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            cmd_ready  <= 1'b1;
            done       <= 1'b0;
            timeout    <= 1'b0;
            verify_err <= 1'b0;
            is_erase_q <= 1'b0;
            tgt_q      <= '0;
            data_q     <= '0;
            step       <= '0;
            wait_ack   <= 1'b0;
            sample_a   <= '0;
            vaddr      <= '0;
            vidx       <= '0;
            timer_load <= 1'b0;
            bus_start  <= 1'b0;
            bus_wr     <= 1'b0;
            bus_addr   <= '0;
            bus_wdata  <= '0;
        end else begin
            bus_start  <= 1'b0;
            done       <= 1'b0;
            timeout    <= 1'b0;
            verify_err <= 1'b0;
            timer_load <= 1'b0;
            case (state)
                SQ_IDLE: if (cmd_valid) begin
                    is_erase_q <= cmd_erase;
                    tgt_q      <= cmd_addr;
                    data_q     <= cmd_data;
                    step       <= '0;
                    wait_ack   <= 1'b0;
                    cmd_ready  <= 1'b0;
                    state      <= SQ_CMD;
                end
                SQ_CMD: if (!wait_ack) begin
                    bus_start <= 1'b1;
                    bus_wr    <= 1'b1;
                    bus_addr  <= step_addr;
                    bus_wdata <= step_data;
                    wait_ack  <= 1'b1;
                end else if (bus_ack) begin
                    wait_ack <= 1'b0;
                    if (step == last_step) begin
                        state      <= SQ_POLL_A;
                        timer_load <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
                SQ_POLL_A, SQ_POLL_B: if (!wait_ack) begin
                    bus_start <= 1'b1;
                    bus_wr    <= 1'b0;
                    bus_addr  <= tgt_q;
                    wait_ack  <= 1'b1;
                end else if (bus_ack) begin
                    wait_ack <= 1'b0;
                    if (state == SQ_POLL_A) begin
                        sample_a <= bus_rdata;
                        state    <= SQ_POLL_B;
                    end else if (toggling && expired) begin
                        done      <= 1'b1;
                        timeout   <= 1'b1;
                        cmd_ready <= 1'b1;
                        state     <= SQ_IDLE;
                    end else if (toggling) begin
                        state <= SQ_POLL_A;
                    end else begin
                        vaddr <= tgt_q;
                        vidx  <= '0;
                        state <= SQ_VERIFY;
                    end
                end
                SQ_VERIFY: if (!wait_ack) begin
                    bus_start <= 1'b1;
                    bus_wr    <= 1'b0;
                    bus_addr  <= vaddr;
                    wait_ack  <= 1'b1;
                end else if (bus_ack) begin
                    wait_ack <= 1'b0;
                    if (bus_rdata != verify_expect) begin
                        done       <= 1'b1;
                        verify_err <= 1'b1;
                        cmd_ready  <= 1'b1;
                        state      <= SQ_IDLE;
                    end else if (!is_erase_q || vidx == LAST_WORD) begin
                        done      <= 1'b1;
                        cmd_ready <= 1'b1;
                        state     <= SQ_IDLE;
                    end else begin
                        vidx  <= vidx + 1'b1;
                        vaddr <= vaddr + WORD_STEP;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    nor_bus_cycle #(
        .AW(ADDR_W), .DW(DW), .SETUP_CLKS(SETUP_CLKS),
        .STROBE_CLKS(STROBE_CLKS), .HOLD_CLKS(HOLD_CLKS)
    ) u_bus (
        .clk(clk), .rst_n(rst_n), .start(bus_start), .wr(bus_wr),
        .addr(bus_addr), .wdata(bus_wdata), .ack(bus_ack), .rdata(bus_rdata),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
        .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    nor_toggle_cmp #(.DW(DW), .SPLIT(INTERLEAVE)) u_tog (
        .first_rd(sample_a), .second_rd(bus_rdata), .toggling(toggling)
    );

    nor_op_timer #(.PROG_TIMEOUT(PROG_TIMEOUT), .ERASE_TIMEOUT(ERASE_TIMEOUT)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(timer_load), .is_erase(is_erase_q), .expired(expired)
    );

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_accept_drops_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    assert_done_with_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cmd_ready);
    assert_flags_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout || verify_err) |-> done);
    assert_timeout_after_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (expired && !verify_err));
    assert_bus_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ready && $past(cmd_ready)) |-> (fl_we_n && fl_oe_n));
endmodule

// File: tb/nor_prog_seq_tb.sv
module nor_prog_seq_tb;
    localparam int BB = 4, AW = 20, DW = 32;
    localparam int PROG_TO = 300, ERASE_TO = 6000;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_erase = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic [DW-1:0] cmd_data = '0;
    logic cmd_ready, done, timeout, verify_err;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_out, fl_dq_in;
    logic fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n;

    always #10 clk = ~clk;

    nor_prog_seq #(
        .BUS_BYTES(BB), .INTERLEAVE(1), .ADDR_W(AW), .CHIP_AW(16), .SECTOR_BYTES(64),
        .SETUP_CLKS(1), .STROBE_CLKS(2), .HOLD_CLKS(1),
        .PROG_TIMEOUT(PROG_TO), .ERASE_TIMEOUT(ERASE_TO)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_erase(cmd_erase), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .done(done), .timeout(timeout), .verify_err(verify_err),
        .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in),
        .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    // ---------------- flash model (bench side) ----------------
    logic clr_log = 1'b0, stuck = 1'b0, hi_only = 1'b0, corrupt_en = 1'b0;
    int   busy_cfg = 0;
    logic [7:0] corrupt_idx = '0;
    logic [DW-1:0] mem [256];
    logic [AW-1:0] log_a [8];
    logic [DW-1:0] log_d [8];
    int wcount, busy_left, we_low, last_we_width;
    logic prev_we, prev_oe, tog;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = '1;
            wcount = 0; busy_left = 0; we_low = 0; last_we_width = 0;
            prev_we = 1'b1; prev_oe = 1'b1; tog = 1'b0; fl_dq_in = '0;
        end else begin
            if (clr_log) wcount = 0;
            if (!fl_we_n) we_low = we_low + 1;
            if (prev_we == 1'b0 && fl_we_n == 1'b1) begin
                last_we_width = we_low; we_low = 0;
                if (wcount < 8) begin log_a[wcount] = fl_addr; log_d[wcount] = fl_dq_out; end
                if (wcount == 3 && log_d[2] == 32'h00A000A0) begin
                    mem[fl_addr[9:2]] = fl_dq_out; busy_left = busy_cfg;
                end
                if (wcount == 5 && fl_dq_out == 32'h00300030) begin
                    for (int i = 0; i < 16; i++) mem[{fl_addr[9:6], 4'(i)}] = '1;
                    busy_left = busy_cfg;
                end
                wcount = wcount + 1;
            end
            if (prev_oe == 1'b1 && fl_oe_n == 1'b0) begin
                if (stuck || busy_left > 0) begin
                    tog = ~tog;
                    fl_dq_in = hi_only ? {9'b0, tog, 22'b0} : {9'b0, tog, 15'b0, tog, 6'b0};
                    if (!stuck) busy_left = busy_left - 1;
                end else begin
                    fl_dq_in = mem[fl_addr[9:2]] ^
                        ((corrupt_en && corrupt_idx == fl_addr[9:2]) ? 32'h1 : 32'h0);
                end
            end
            prev_we = fl_we_n; prev_oe = fl_oe_n;
        end
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0;
    int cyc;
    logic got_to, got_err;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic er, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic jam);
        @(negedge clk);
        clr_log = 1'b1;
        cmd_valid = 1'b1; cmd_erase = er; cmd_addr = a; cmd_data = d;
        @(negedge clk);
        clr_log = 1'b0;
        if (jam) begin
            cmd_addr = 20'h0F000; cmd_erase = 1'b1;
        end else begin
            cmd_valid = 1'b0;
        end
        cyc = 1;
        if (jam) chk(cmd_ready == 1'b0, "R11 ready low while busy", 64'(cmd_ready), 64'd0);
        while (!done && cyc < WD_LIMIT) begin
            @(negedge clk); cyc++;
        end
        chk(cyc < WD_LIMIT, "watchdog", 64'(cyc), 64'(WD_LIMIT));
        got_to = timeout; got_err = verify_err;
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic chk_wr(input int i, input logic [AW-1:0] ea, input logic [DW-1:0] ed, input string req);
        chk(log_a[i] == ea, req, 64'(log_a[i]), 64'(ea));
        chk(log_d[i] == ed, req, 64'(log_d[i]), 64'(ed));
    endtask

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [7:0]    busy;
        logic          corrupt;
        logic          hi;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{20'h00040, 32'h12345678, 8'd3, 1'b0, 1'b0},
        '{20'h000A4, 32'hDEADBEEF, 8'd0, 1'b0, 1'b0},
        '{20'h00100, 32'h0000FFFF, 8'd8, 1'b0, 1'b1},
        '{20'h10020, 32'hA5A50F0F, 8'd2, 1'b0, 1'b0},
        '{20'h00200, 32'h00000001, 8'd4, 1'b1, 1'b0},
        '{20'h003FC, 32'hFFFF0000, 8'd5, 1'b0, 1'b1}
    };

    initial begin : watchdog
        #(64'd20 * 64'd200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cmd_ready === 1'b1, "R1 ready", 64'(cmd_ready), 64'd1);
        chk(done === 1'b0, "R1 done", 64'(done), 64'd0);
        chk({fl_ce_n, fl_we_n, fl_oe_n} === 3'b111, "R1 strobes", 64'({fl_ce_n, fl_we_n, fl_oe_n}), 64'd7);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: program requests (R2, R3, R5, R6, R7, R8)
        for (int v = 0; v < 6; v++) begin
            busy_cfg = int'(VECS[v].busy); hi_only = VECS[v].hi;
            corrupt_en = VECS[v].corrupt; corrupt_idx = VECS[v].addr[9:2];
            run_op(1'b0, VECS[v].addr, VECS[v].data, 1'b0);
            base = VECS[v].addr & 20'hF0000;
            chk(wcount == 4, "R3 write count", 64'(wcount), 64'd4);
            chk_wr(0, base | 20'h01554, 32'h00AA00AA, "R2 R5 unlock first");
            chk_wr(1, base | 20'h00AA8, 32'h00550055, "R2 R5 unlock second");
            chk_wr(2, base | 20'h01554, 32'h00A000A0, "R3 R5 program op");
            chk_wr(3, VECS[v].addr, VECS[v].data, "R3 R5 data word");
            chk(got_to == 1'b0, "R7 no timeout", 64'(got_to), 64'd0);
            chk(got_err == VECS[v].corrupt, "R7 R8 verify flag", 64'(got_err), 64'(VECS[v].corrupt));
            chk(last_we_width == 2, "R6 strobe width", 64'(last_we_width), 64'd2);
            corrupt_en = 1'b0; hi_only = 1'b0;
        end

        // R4, R9: clean erase of sector 0x80
        busy_cfg = 6;
        run_op(1'b1, 20'h00080, '0, 1'b0);
        chk(wcount == 6, "R4 write count", 64'(wcount), 64'd6);
        chk_wr(0, 20'h01554, 32'h00AA00AA, "R4 first key");
        chk_wr(1, 20'h00AA8, 32'h00550055, "R4 second key");
        chk_wr(2, 20'h01554, 32'h00800080, "R4 arm");
        chk_wr(3, 20'h01554, 32'h00AA00AA, "R4 first key again");
        chk_wr(4, 20'h00AA8, 32'h00550055, "R4 second key again");
        chk_wr(5, 20'h00080, 32'h00300030, "R4 sector go");
        chk(got_err == 1'b0 && got_to == 1'b0, "R9 clean erase", 64'({got_to, got_err}), 64'd0);

        // R9: last word of sector 0xC0 reads back wrong
        corrupt_en = 1'b1; corrupt_idx = 8'd63; busy_cfg = 2;
        run_op(1'b1, 20'h000C0, '0, 1'b0);
        chk(got_err == 1'b1, "R9 last word mismatch", 64'(got_err), 64'd1);
        corrupt_en = 1'b0;

        // R10: program never settles
        stuck = 1'b1;
        run_op(1'b0, 20'h00300, 32'h01020304, 1'b0);
        chk(got_to == 1'b1 && got_err == 1'b0, "R10 program timeout flags", 64'({got_to, got_err}), 64'h2);
        chk(cyc >= PROG_TO && cyc <= PROG_TO + 100, "R10 program window", 64'(cyc), 64'(PROG_TO));

        // R10: erase never settles
        run_op(1'b1, 20'h00340, '0, 1'b0);
        chk(got_to == 1'b1 && got_err == 1'b0, "R10 erase timeout flags", 64'({got_to, got_err}), 64'h2);
        chk(cyc >= ERASE_TO && cyc <= ERASE_TO + 120, "R10 erase window", 64'(cyc), 64'(ERASE_TO));
        stuck = 1'b0;

        // R11: request held on the port while busy is ignored
        busy_cfg = 2;
        run_op(1'b0, 20'h00044, 32'h55AA33CC, 1'b1);
        chk(wcount == 4, "R11 no extra writes", 64'(wcount), 64'd4);
        chk_wr(3, 20'h00044, 32'h55AA33CC, "R11 data write of accepted request");
        chk(cmd_ready == 1'b1, "R11 ready after done", 64'(cmd_ready), 64'd1);
        chk(got_err == 1'b0, "R11 verify clean", 64'(got_err), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule